// File: doc/BRIEF.md
# Buffer Slice Allocator

This block hands out fixed 2 KiB slices of two small on-chip buffer memories, one serving transmit channels and one serving receive channels, to DMA channels as they come up. Each memory is modelled as an occupancy bitmap with one bit per slice. The number of slices that exist is set by a memory-size input per pool, so the same block serves buffers from 2 KiB up to 64 KiB (32 slices).

A channel asks for a slice by raising `alloc_req` with `alloc_dir` naming the pool. In the same cycle the block either grants it a packed carveout word holding the slice size and byte base, or grants it with a busy flag when the pool is full. A channel gives its slice back by presenting the carveout word on the release port. A release whose base lies outside the configured memory is refused and flagged. One operation completes per cycle, and a release takes precedence over a request that arrives with it.

Top module: `buf_slice_alloc`

## Requirements
- R1: Slices are 2048 bytes. A pool has floor(mem_size/2048) usable slices, at most 32 (mem_size up to 65536). A slice at or beyond that count is never granted.
- R2: `alloc_gnt` is high in exactly the cycles where `alloc_req` is high and `rel_valid` is low. `alloc_dir`=0 selects the transmit pool and 1 selects the receive pool. The two pools never affect each other.
- R3: A successful grant picks the lowest-index free usable slice. That slice counts as used from the next cycle on.
- R4: When no usable slice is free, the grant carries `alloc_busy`=1 and `alloc_word`=0, and no pool changes state.
- R5: On a successful grant, `alloc_word[31:16]` is 2048 and `alloc_word[15:0]` is the slice index times 2048. `alloc_word` is 0 whenever `alloc_gnt` is low.
- R6: A release frees slice `rel_word[15:0]`/2048 (the index is bits 15:11) in the pool chosen by `rel_dir` (0 transmit, 1 receive). `rel_word[31:16]` is ignored. Releasing a slice that is already free changes nothing and raises no warning.
- R7: A release whose base `rel_word[15:0]` is at or above the pool's mem_size changes no state and drives `rel_warn` high in that cycle. `rel_warn` is low in every other cycle.
- R8: When `rel_valid` and `alloc_req` are high together, only the release is carried out. A request held into the next cycle can then be granted the slice just freed.
- R9: After reset, every slice of both pools is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mem_size | input | 17 | Transmit memory size in bytes |
| rx_mem_size | input | 17 | Receive memory size in bytes |
| alloc_req | input | 1 | Allocation request |
| alloc_dir | input | 1 | Pool for the request: 0 transmit, 1 receive |
| alloc_gnt | output | 1 | Request answered this cycle |
| alloc_busy | output | 1 | Answer is "no slice free" |
| alloc_word | output | 32 | Carveout: size[31:16], base[15:0] |
| rel_valid | input | 1 | Release request |
| rel_dir | input | 1 | Pool for the release: 0 transmit, 1 receive |
| rel_word | input | 32 | Carveout word being returned |
| rel_warn | output | 1 | Release base out of range, ignored |

## Verification
The bench fills each pool to its last slice and asks once more. A design that counted slices wrongly would either grant a slice past the end of a pool whose size is not a multiple of 2048, or report busy too early. The bench frees slices in an order that leaves holes out of sequence. A search that is not lowest-first, or a release that decodes the index from the wrong bits, would then hand back a different base than the reference model expects. The bench makes a release collide with a request, makes a release land exactly on the size boundary, releases a slice that is already free, and changes a size input while slices are held. Each of these would show up as a grant in the wrong cycle, a state change that should not have happened, or a spurious warning.

// File: rtl/buf_slice_alloc_pkg.sv
package buf_slice_alloc_pkg;
  localparam int unsigned CARVE_FIELD_W = 16;

  typedef struct packed {
    logic [CARVE_FIELD_W-1:0] size;
    logic [CARVE_FIELD_W-1:0] base;
  } carveout_t;

  typedef enum logic {
    POOL_TX = 1'b0,
    POOL_RX = 1'b1
  } pool_sel_e;
endpackage

// File: rtl/slice_first_free.sv
module slice_first_free #(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     free_vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/slice_pool.sv
module slice_pool #(
  parameter int unsigned MAX_SLICES = 32,
  parameter int unsigned SIZE_W     = 17,
  parameter int unsigned SLICE_SH   = 11,
  parameter int unsigned IDX_W      = $clog2(MAX_SLICES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SIZE_W-1:0]     mem_size,
  input  logic                  alloc_en,
  input  logic                  rel_en,
  input  logic [15:0]           rel_base,
  output logic                  grant_ok,
  output logic [IDX_W-1:0]      grant_idx,
  output logic                  rel_bad,
  output logic [MAX_SLICES-1:0] occ
);
  logic [SIZE_W-1:0]     n_slices;
  logic [MAX_SLICES-1:0] usable;
  logic [MAX_SLICES-1:0] occ_nxt;
  logic [IDX_W-1:0]      rel_idx;
  logic                  rel_do;
  logic                  alloc_do;
  logic                  occ_en;

  assign n_slices = mem_size >> SLICE_SH;

  for (genvar g = 0; g < MAX_SLICES; g++) begin : g_usable
    assign usable[g] = (SIZE_W'(g) < n_slices);
  end

  slice_first_free #(.N(MAX_SLICES), .IDX_W(IDX_W)) u_ff (
    .free_vec (usable & ~occ),
    .found    (grant_ok),
    .idx      (grant_idx)
  );

  assign rel_idx  = rel_base[SLICE_SH +: IDX_W];
  assign rel_bad  = rel_en & (SIZE_W'(rel_base) >= mem_size);
  assign rel_do   = rel_en & ~rel_bad;
  assign alloc_do = alloc_en & grant_ok;
  assign occ_en   = rel_do | alloc_do;

  always_comb begin
    occ_nxt = occ;
    if (rel_do) begin
      occ_nxt[rel_idx] = 1'b0;
    end else if (alloc_do) begin
      occ_nxt[grant_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
    end else if (occ_en) begin
      occ <= occ_nxt;
    end
  end
endmodule

// File: rtl/buf_slice_alloc.sv
module buf_slice_alloc
  import buf_slice_alloc_pkg::*;
#(
  parameter int unsigned SLICE_BYTES = 2048,
  parameter int unsigned MAX_SLICES  = 32,
  parameter int unsigned SIZE_W      = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] tx_mem_size,
  input  logic [SIZE_W-1:0] rx_mem_size,
  input  logic              alloc_req,
  input  logic              alloc_dir,
  output logic              alloc_gnt,
  output logic              alloc_busy,
  output logic [31:0]       alloc_word,
  input  logic              rel_valid,
  input  logic              rel_dir,
  input  logic [31:0]       rel_word,
  output logic              rel_warn
);
  localparam int unsigned SLICE_SH = $clog2(SLICE_BYTES);
  localparam int unsigned IDX_W    = $clog2(MAX_SLICES);
  localparam int unsigned NPOOL    = 2;

  logic [SIZE_W-1:0]     pool_size [NPOOL];
  logic                  pool_ok   [NPOOL];
  logic [IDX_W-1:0]      pool_idx  [NPOOL];
  logic                  pool_bad  [NPOOL];
  logic [MAX_SLICES-1:0] pool_occ  [NPOOL];
  logic [MAX_SLICES-1:0] tx_occ;
  logic [MAX_SLICES-1:0] rx_occ;
  carveout_t             rel_cw;
  carveout_t             grant_cw;
  logic                  sel_ok;
  logic [IDX_W-1:0]      sel_idx;

  assign pool_size[POOL_TX] = tx_mem_size;
  assign pool_size[POOL_RX] = rx_mem_size;
  assign rel_cw    = carveout_t'(rel_word);
  assign alloc_gnt = alloc_req & ~rel_valid;

  for (genvar p = 0; p < NPOOL; p++) begin : g_pool
    slice_pool #(
      .MAX_SLICES (MAX_SLICES),
      .SIZE_W     (SIZE_W),
      .SLICE_SH   (SLICE_SH),
      .IDX_W      (IDX_W)
    ) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_size  (pool_size[p]),
      .alloc_en  (alloc_gnt & (alloc_dir == 1'(p))),
      .rel_en    (rel_valid & (rel_dir == 1'(p))),
      .rel_base  (rel_cw.base),
      .grant_ok  (pool_ok[p]),
      .grant_idx (pool_idx[p]),
      .rel_bad   (pool_bad[p]),
      .occ       (pool_occ[p])
    );
  end

  assign tx_occ  = pool_occ[POOL_TX];
  assign rx_occ  = pool_occ[POOL_RX];
  assign sel_ok  = alloc_dir ? pool_ok[POOL_RX]  : pool_ok[POOL_TX];
  assign sel_idx = alloc_dir ? pool_idx[POOL_RX] : pool_idx[POOL_TX];

  always_comb begin
    grant_cw = '0;
    if (alloc_gnt && sel_ok) begin
      grant_cw.size = CARVE_FIELD_W'(SLICE_BYTES);
      grant_cw.base = CARVE_FIELD_W'(sel_idx) << SLICE_SH;
    end
  end

  assign alloc_word = grant_cw;
  assign alloc_busy = alloc_gnt & ~sel_ok;
  assign rel_warn   = rel_dir ? pool_bad[POOL_RX] : pool_bad[POOL_TX];
endmodule

// File: rtl/buf_slice_alloc_chk.sv
module buf_slice_alloc_chk #(
  parameter int unsigned SLICE_BYTES = 2048,
  parameter int unsigned MAX_SLICES  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  alloc_req,
  input logic                  alloc_dir,
  input logic                  alloc_gnt,
  input logic                  alloc_busy,
  input logic [31:0]           alloc_word,
  input logic                  rel_valid,
  input logic                  rel_warn,
  input logic [MAX_SLICES-1:0] tx_occ,
  input logic [MAX_SLICES-1:0] rx_occ
);
  localparam int unsigned SH    = $clog2(SLICE_BYTES);
  localparam int unsigned IDX_W = $clog2(MAX_SLICES);

  AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> !alloc_gnt); // R8
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |-> alloc_req); // R2
  AST_SIZE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt && !alloc_busy) |-> (alloc_word[31:16] == 16'(SLICE_BYTES))); // R5
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt && !alloc_busy) |-> (alloc_word[SH-1:0] == '0)); // R5
  AST_BUSY_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_busy |-> (alloc_word == 32'd0)); // R4
  AST_BUSY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_busy |=> ($stable(tx_occ) && $stable(rx_occ))); // R4
  AST_TX_SLICE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt && !alloc_busy && !alloc_dir) |=>
      tx_occ[$past(alloc_word[SH +: IDX_W])]); // R3
  AST_RX_SLICE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt && !alloc_busy && alloc_dir) |=>
      rx_occ[$past(alloc_word[SH +: IDX_W])]); // R3
  AST_WARN_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_warn |=> ($stable(tx_occ) && $stable(rx_occ))); // R7
  AST_WARN_ONLY_REL: assert property (@(posedge clk) disable iff (!rst_n)
    rel_warn |-> rel_valid); // R7
endmodule

bind buf_slice_alloc buf_slice_alloc_chk #(
  .SLICE_BYTES (SLICE_BYTES),
  .MAX_SLICES  (MAX_SLICES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_req  (alloc_req),
  .alloc_dir  (alloc_dir),
  .alloc_gnt  (alloc_gnt),
  .alloc_busy (alloc_busy),
  .alloc_word (alloc_word),
  .rel_valid  (rel_valid),
  .rel_warn   (rel_warn),
  .tx_occ     (tx_occ),
  .rx_occ     (rx_occ)
);

// File: tb/tb_buf_slice_alloc.sv
module tb_buf_slice_alloc;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [16:0] tx_mem_size;
  logic [16:0] rx_mem_size;
  logic        alloc_req;
  logic        alloc_dir;
  logic        alloc_gnt;
  logic        alloc_busy;
  logic [31:0] alloc_word;
  logic        rel_valid;
  logic        rel_dir;
  logic [31:0] rel_word;
  logic        rel_warn;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  bit model_used [2][32];

  buf_slice_alloc dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_mem_size (tx_mem_size),
    .rx_mem_size (rx_mem_size),
    .alloc_req   (alloc_req),
    .alloc_dir   (alloc_dir),
    .alloc_gnt   (alloc_gnt),
    .alloc_busy  (alloc_busy),
    .alloc_word  (alloc_word),
    .rel_valid   (rel_valid),
    .rel_dir     (rel_dir),
    .rel_word    (rel_word),
    .rel_warn    (rel_warn)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Drive one cycle, compare with the reference, then advance the model.
  task automatic step(input bit req, input bit dir, input bit rv, input bit rd,
                      input logic [31:0] rw, input string tag);
    int size;
    int nsl;
    int pick;
    bit e_gnt;
    bit e_busy;
    bit e_warn;
    logic [31:0] e_word;
    alloc_req = req; alloc_dir = dir;
    rel_valid = rv;  rel_dir   = rd; rel_word = rw;
    #(CLK_PERIOD / 4);
    size  = dir ? int'(rx_mem_size) : int'(tx_mem_size);
    nsl   = size / 2048;
    if (nsl > 32) nsl = 32;
    pick  = -1;
    for (int i = nsl - 1; i >= 0; i--) if (!model_used[dir][i]) pick = i;
    e_gnt  = req && !rv;
    e_busy = e_gnt && (pick < 0);
    e_word = (e_gnt && pick >= 0) ? {16'd2048, 16'(pick * 2048)} : 32'd0;
    e_warn = rv && (int'(rw[15:0]) >= (rd ? int'(rx_mem_size) : int'(tx_mem_size)));
    checks++;
    if (alloc_gnt !== e_gnt || alloc_busy !== e_busy || alloc_word !== e_word ||
        rel_warn !== e_warn) begin
      failures++;
      $display("FAIL %s: gnt/busy/word/warn = %b/%b/%h/%b expected %b/%b/%h/%b",
               tag, alloc_gnt, alloc_busy, alloc_word, rel_warn,
               e_gnt, e_busy, e_word, e_warn);
    end
    @(posedge clk);
    if (rv && !e_warn) model_used[rd][rw[15:11]] = 1'b0;
    else if (e_gnt && pick >= 0) model_used[dir][pick] = 1'b1;
    @(negedge clk);
  endtask

  task automatic alloc(input bit dir, input string tag);
    step(1'b1, dir, 1'b0, 1'b0, 32'd0, tag);
  endtask

  task automatic rel(input bit dir, input int base, input string tag);
    step(1'b0, 1'b0, 1'b1, dir, {16'hBEEF, 16'(base)}, tag);
  endtask

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0;
    alloc_req = 0; alloc_dir = 0; rel_valid = 0; rel_dir = 0; rel_word = '0;
    tx_mem_size = 17'h10000;
    rx_mem_size = 17'(6 * 2048 + 100);
    for (int p = 0; p < 2; p++) for (int i = 0; i < 32; i++) model_used[p][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    step(1'b0, 1'b0, 1'b0, 1'b0, 32'd0, "R9 idle after reset");
    alloc(1'b0, "R9 R5 first tx grant at base 0");
    for (int i = 1; i < 32; i++) alloc(1'b0, "R3 R1 tx fill");
    alloc(1'b0, "R4 R1 tx full answers busy");
    alloc(1'b0, "R4 tx busy again, no change");
    for (int i = 0; i < 6; i++) alloc(1'b1, "R2 R1 rx fill, tx full ignored");
    alloc(1'b1, "R1 rx partial slice not granted, busy");
    rel(1'b0, 5 * 2048, "R6 release tx slice 5, size field ignored");
    alloc(1'b0, "R3 tx regrant slice 5");
    rel(1'b1, 6 * 2048 + 100, "R7 release rx at size boundary warns");
    alloc(1'b1, "R7 rx still full after refused release");
    rel(1'b1, 6 * 2048 + 99, "R6 release rx past last slice, harmless");
    rel(1'b1, 65535, "R7 release rx far out of range");
    step(1'b1, 1'b1, 1'b1, 1'b1, {16'd2048, 16'(2 * 2048)}, "R8 release beats alloc");
    alloc(1'b1, "R8 held request gets freed rx slice 2");
    rel(1'b0, 3 * 2048, "R6 release tx 3");
    rel(1'b0, 3 * 2048, "R6 release tx 3 again, no warn");
    rel(1'b0, 1 * 2048, "R6 release tx 1");
    rel(1'b0, 1 * 2048 + 17, "R6 unaligned base frees slice 1 again");
    alloc(1'b0, "R3 lowest hole tx 1 first");
    alloc(1'b0, "R3 then tx 3");
    alloc(1'b0, "R4 tx full again");
    rel(1'b1, 0, "R2 rx release leaves tx alone");
    alloc(1'b0, "R2 tx still busy");
    tx_mem_size = 17'd4096;
    rel(1'b0, 4096, "R7 tx base equals shrunk size");
    rel(1'b0, 0, "R6 tx slice 0 in shrunk pool");
    alloc(1'b0, "R1 shrunk pool regrants 0");
    alloc(1'b0, "R1 shrunk pool busy");
    tx_mem_size = 17'd20000;
    rx_mem_size = 17'h10000;
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], lfsr[2] & lfsr[3], lfsr[4],
           {lfsr, lfsr[15:11] ^ lfsr[4:0], 11'(lfsr)}, "R3 R6 R8 mixed traffic");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule